// File: doc/BRIEF.md
# Debug Halt and Memory Load Sequencer

This block sits on the host side of a two-wire serial debug link. It drives an external transaction engine that performs single debug-port and access-port register writes and hands back the three-bit acknowledge for each one. A start pulse runs a fixed recipe. The recipe powers up the debug and system domains, holds the core in reset through a vendor reset-control access port, and enables halting debug. It then arms reset-vector catch, requests a system reset and releases the core, which leaves the core halted on its first instruction. The memory access port is set up for 32-bit accesses with single auto-increment. The block then loads a stream of words into target memory, starting at a given base address.

Words arrive on a valid/ready stream. The sequencer raises `wr_ready` only when it is free to take the next word. The producer keeps `wr_data` and `wr_last` stable while `wr_valid` is high and the word has not been taken. The command side to the engine also follows valid/ready: a command is transferred on a cycle where `cmd_valid` and `cmd_ready` are both high. The engine then answers each accepted command with exactly one `rsp_valid` pulse carrying the acknowledge. Back-pressure on either side only stalls the sequence and never changes its order.

A WAIT acknowledge repeats the same access up to a programmable limit. A FAULT clears the sticky flags through the abort register and ends the run with an error. Any other acknowledge ends the run at once. The block reports completion, an error code and the number of words stored.

Top module: `swd_halt_loader`

## Requirements
- R1: After reset, `busy`, `done`, `cmd_valid` and `wr_ready` are 0, `err_code` is 0 and `words_written` is 0. A `start` pulse while idle begins a run, and a `start` while `busy` is high has no effect on the command sequence.
- R2: A run issues these writes in this order (DP register fields: ABORT A=00, CTRL/STAT A=01, SELECT A=10; memory-port fields: CSW A=00, TAR A=01, DRW A=11). CTRL/STAT gets 0x50000000 (bits 28 and 30). Reset-control (port 0x0A, A=01) gets 0x08. CSW gets 0x00000012. Then TAR/DRW pairs write 0xA05F0001 to 0xE000EDF0, 0x00000001 to 0xE000EDFC and 0xFA050004 to 0xE000ED0C. Reset-control then gets 0x00. Finally TAR gets `base_addr`, once.
- R3: A SELECT write {port[31:24], 16'h0, bank[7:4], 4'h0} comes before an access-port write only when the port number or bank differs from the last acknowledged SELECT. A new run forgets the last SELECT.
- R4: After TAR, each word taken on the stream is written to DRW in arrival order. The run ends successfully after the DRW write of the word that carried `wr_last`. `wr_ready` is high only while the sequencer waits for a word.
- R5: A WAIT acknowledge (3'b010) reissues the identical write. The write is sent at most `wait_limit`+1 times. The WAIT that would exceed the limit ends the run with `err_code`=2 and no further commands.
- R6: A FAULT acknowledge (3'b100) is followed by one ABORT write of 0x0000001E, after which the run ends with `err_code`=1.
- R7: Any acknowledge other than OK (3'b001), WAIT or FAULT ends the run at once with `err_code`=3.
- R8: `done` is a one-cycle pulse when a run ends, coinciding with `busy` falling. `err_code` (0 for success) holds until the next start. `words_written` counts DRW stream writes acknowledged OK in the current run.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and the command fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| base_addr | input | 32 | First target memory address for the word stream |
| wait_limit | input | WAIT_W | Maximum WAIT retries per write |
| wr_valid | input | 1 | Stream word present |
| wr_ready | output | 1 | Sequencer takes the word this cycle |
| wr_data | input | 32 | Stream word |
| wr_last | input | 1 | Marks the final word of the run |
| cmd_valid | output | 1 | Register write command present |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_apndp | output | 1 | 1 = access-port register, 0 = debug-port register |
| cmd_addr | output | 2 | Register address bits [3:2] |
| cmd_wdata | output | 32 | Write value |
| rsp_valid | input | 1 | Acknowledge for the accepted command |
| rsp_ack | input | 3 | Acknowledge code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 fault, 2 wait timeout, 3 bad acknowledge |
| words_written | output | CNT_W | Words stored in this run |

## Verification
The bench builds the block with CNT_W=8 and WAIT_W=4. With these values, wait limits of 0, 2 and 3 push the timeout and successful-retry cases through within a handful of cycles, and a limit of 0 shows that a single WAIT alone ends the run. A responder model in the bench toggles `cmd_ready` to put back-pressure on the command side. It can also inject WAIT, FAULT or an illegal acknowledge at any chosen position of the command stream, so the abort path and the early stop are reached at the halt-recipe and stream stages alike. Gaps between stream words hold the sequencer in its word-wait state across several cycles.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_FAULT   = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_PROTO   = 2'd3
  } err_e;

  typedef enum logic [1:0] {OP_FIXED, OP_TAR_BASE, OP_STREAM} op_kind_e;

  typedef struct packed {
    op_kind_e    kind;
    logic        ap;
    logic [7:0]  apsel;
    logic [3:0]  bank;
    logic [1:0]  a;
    logic [31:0] data;
  } op_t;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam logic [1:0] DPA_ABORT  = 2'b00;
  localparam logic [1:0] DPA_CTRL   = 2'b01;
  localparam logic [1:0] DPA_SELECT = 2'b10;
  localparam logic [1:0] APA_CSW    = 2'b00;
  localparam logic [1:0] APA_TAR    = 2'b01;
  localparam logic [1:0] APA_DRW    = 2'b11;
  localparam logic [1:0] APA_RSTCTL = 2'b01;

  localparam logic [7:0]  PORT_MEM    = 8'h00;
  localparam logic [7:0]  PORT_RSTCTL = 8'h0A;
  localparam logic [31:0] PWRUP_REQ   = 32'h5000_0000;
  localparam logic [31:0] CSW_W32_INC = 32'h0000_0012;
  localparam logic [31:0] STICKY_CLR  = 32'h0000_001E;

  localparam int NUM_STEPS = 12;
endpackage

// File: rtl/swd_seq_steps.sv
module swd_seq_steps
  import swd_seq_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic [STEP_W-1:0] step,
  input  logic [31:0]       base_addr,
  output op_t               op
);
  always_comb begin
    op.kind  = OP_FIXED;
    op.ap    = 1'b1;
    op.apsel = PORT_MEM;
    op.bank  = 4'h0;
    op.a     = APA_DRW;
    op.data  = 32'h0;
    case (step)
      4'd0:  begin op.ap = 1'b0; op.a = DPA_CTRL; op.data = PWRUP_REQ; end
      4'd1:  begin op.apsel = PORT_RSTCTL; op.a = APA_RSTCTL; op.data = 32'h8; end
      4'd2:  begin op.a = APA_CSW; op.data = CSW_W32_INC; end
      4'd3:  begin op.a = APA_TAR; op.data = 32'hE000_EDF0; end
      4'd4:  op.data = 32'hA05F_0001;
      4'd5:  begin op.a = APA_TAR; op.data = 32'hE000_EDFC; end
      4'd6:  op.data = 32'h0000_0001;
      4'd7:  begin op.a = APA_TAR; op.data = 32'hE000_ED0C; end
      4'd8:  op.data = 32'hFA05_0004;
      4'd9:  begin op.apsel = PORT_RSTCTL; op.a = APA_RSTCTL; op.data = 32'h0; end
      4'd10: begin op.kind = OP_TAR_BASE; op.a = APA_TAR; op.data = base_addr; end
      default: op.kind = OP_STREAM;
    endcase
  end
endmodule

// File: rtl/swd_seq_selcache.sv
module swd_seq_selcache (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inv,
  input  logic       upd,
  input  logic [7:0] want_port,
  input  logic [3:0] want_bank,
  output logic       miss
);
  logic       vld_q;
  logic [7:0] port_q;
  logic [3:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      port_q <= '0;
      bank_q <= '0;
    end else if (inv) begin
      vld_q <= 1'b0;
    end else if (upd) begin
      vld_q  <= 1'b1;
      port_q <= want_port;
      bank_q <= want_bank;
    end
  end

  assign miss = !vld_q || (port_q != want_port) || (bank_q != want_bank);

  // R3
  sel_hit_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !inv) |=> (vld_q && port_q == $past(want_port) && bank_q == $past(want_bank)));
endmodule

// File: rtl/swd_seq_retry.sv
module swd_seq_retry #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [WAIT_W-1:0] limit,
  output logic              exhausted
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign exhausted = (cnt_q >= limit);

  // R5
  retry_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (cnt_q < limit));
endmodule

// File: rtl/swd_halt_loader.sv
module swd_halt_loader
  import swd_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       base_addr,
  input  logic [WAIT_W-1:0] wait_limit,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [31:0]       wr_data,
  input  logic              wr_last,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_apndp,
  output logic [1:0]        cmd_addr,
  output logic [31:0]       cmd_wdata,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_ack,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [CNT_W-1:0]  words_written
);
  localparam int STEP_W = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_FIXED = STEP_W'(NUM_STEPS - 2);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_RESP} state_e;
  typedef enum logic [1:0] {K_OP, K_SEL, K_ABORT} issue_e;

  state_e            state_q;
  issue_e            iss_q, iss_now;
  logic [STEP_W-1:0] step_q;
  logic [31:0]       word_q;
  logic              last_q, abort_q;
  err_e              err_q;
  op_t               op;
  logic              sel_miss, sel_upd, sel_inv;
  logic              rty_clr, rty_inc, rty_done;
  logic              accept;

  swd_seq_steps #(.STEP_W(STEP_W)) u_steps (
    .step(step_q), .base_addr(base_addr), .op(op)
  );

  swd_seq_selcache u_sel (
    .clk(clk), .rst_n(rst_n), .inv(sel_inv), .upd(sel_upd),
    .want_port(op.apsel), .want_bank(op.bank), .miss(sel_miss)
  );

  swd_seq_retry #(.WAIT_W(WAIT_W)) u_rty (
    .clk(clk), .rst_n(rst_n), .clr(rty_clr), .inc(rty_inc),
    .limit(wait_limit), .exhausted(rty_done)
  );

  // Which write goes out in the current issue slot.
  always_comb begin
    if (abort_q)               iss_now = K_ABORT;
    else if (op.ap && sel_miss) iss_now = K_SEL;
    else                       iss_now = K_OP;
  end

  always_comb begin
    cmd_valid = (state_q == S_ISSUE);
    unique case (iss_now)
      K_ABORT: begin cmd_apndp = 1'b0; cmd_addr = DPA_ABORT;  cmd_wdata = STICKY_CLR; end
      K_SEL:   begin cmd_apndp = 1'b0; cmd_addr = DPA_SELECT;
                     cmd_wdata = {op.apsel, 16'h0, op.bank, 4'h0}; end
      default: begin cmd_apndp = op.ap; cmd_addr = op.a;
                     cmd_wdata = (op.kind == OP_STREAM) ? word_q : op.data; end
    endcase
  end

  assign accept   = (state_q == S_IDLE) && start;
  assign wr_ready = (state_q == S_FETCH);
  assign busy     = (state_q != S_IDLE);
  assign err_code = err_q;

  wire resp = (state_q == S_RESP) && rsp_valid;
  assign sel_inv = accept;
  assign sel_upd = resp && (rsp_ack == ACK_OK) && (iss_q == K_SEL);
  assign rty_inc = resp && (rsp_ack == ACK_WAIT) && !rty_done;
  assign rty_clr = accept || (resp && (rsp_ack == ACK_OK || rsp_ack == ACK_FAULT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      iss_q         <= K_OP;
      step_q        <= '0;
      word_q        <= '0;
      last_q        <= 1'b0;
      abort_q       <= 1'b0;
      err_q         <= ERR_NONE;
      done          <= 1'b0;
      words_written <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          state_q       <= S_ISSUE;
          step_q        <= '0;
          abort_q       <= 1'b0;
          err_q         <= ERR_NONE;
          words_written <= '0;
        end
        S_FETCH: if (wr_valid) begin
          word_q  <= wr_data;
          last_q  <= wr_last;
          state_q <= S_ISSUE;
        end
        S_ISSUE: if (cmd_ready) begin
          iss_q   <= iss_now;
          state_q <= S_RESP;
        end
        default: if (rsp_valid) begin
          if (rsp_ack == ACK_OK) begin
            if (iss_q == K_ABORT) begin
              state_q <= S_IDLE; done <= 1'b1;
            end else if (iss_q == K_SEL) begin
              state_q <= S_ISSUE;
            end else if (op.kind == OP_STREAM) begin
              words_written <= words_written + 1'b1;
              if (last_q) begin state_q <= S_IDLE; done <= 1'b1; end
              else state_q <= S_FETCH;
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= (step_q == LAST_FIXED) ? S_FETCH : S_ISSUE;
            end
          end else if (rsp_ack == ACK_WAIT) begin
            if (rty_done) begin
              err_q <= ERR_TIMEOUT; state_q <= S_IDLE; done <= 1'b1;
            end else state_q <= S_ISSUE;
          end else if (rsp_ack == ACK_FAULT) begin
            if (iss_q == K_ABORT) begin
              state_q <= S_IDLE; done <= 1'b1;
            end else begin
              err_q <= ERR_FAULT; abort_q <= 1'b1; state_q <= S_ISSUE;
            end
          end else begin
            err_q <= ERR_PROTO; state_q <= S_IDLE; done <= 1'b1;
          end
        end
      endcase
    end
  end

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable({cmd_apndp, cmd_addr, cmd_wdata})));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(words_written) |-> (words_written == $past(words_written) + 1'b1 || words_written == '0));

  // R4
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ready, cmd_valid}));
endmodule

// File: tb/swd_halt_loader_tb.sv
module swd_halt_loader_tb;
  localparam int CNT_W  = 8;
  localparam int WAIT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              start = 1'b0;
  logic [31:0]       base_addr = 32'h2000_0000;
  logic [WAIT_W-1:0] wait_limit = 4'd3;
  logic              wr_valid = 1'b0, wr_last = 1'b0, wr_ready;
  logic [31:0]       wr_data = '0;
  logic              cmd_valid, cmd_apndp;
  logic              cmd_ready;
  logic [1:0]        cmd_addr;
  logic [31:0]       cmd_wdata;
  logic              rsp_valid;
  logic [2:0]        rsp_ack;
  logic              busy, done;
  logic [1:0]        err_code;
  logic [CNT_W-1:0]  words_written;

  swd_halt_loader #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .wait_limit(wait_limit), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_apndp(cmd_apndp), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .busy(busy), .done(done), .err_code(err_code), .words_written(words_written)
  );

  int checks = 0, errors = 0;

  // Responder model: logs accepted writes, answers one cycle later.
  logic        stall = 1'b0, log_clr = 1'b0;
  int          nlog = 0;
  int          wait_idx = 999, wait_n = 0, fault_idx = 999, bad_idx = 999;
  logic        lg_ap [64];
  logic [1:0]  lg_a  [64];
  logic [31:0] lg_d  [64];

  function automatic logic [2:0] ack_for(int i);
    if (i == bad_idx)                          return 3'b111;
    if (i == fault_idx)                        return 3'b100;
    if (i >= wait_idx && i < wait_idx + wait_n) return 3'b010;
    return 3'b001;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ready <= 1'b1; rsp_valid <= 1'b0; rsp_ack <= 3'b000; nlog <= 0;
    end else begin
      rsp_valid <= 1'b0;
      cmd_ready <= stall ? ~cmd_ready : 1'b1;
      if (log_clr) nlog <= 0;
      else if (cmd_valid && cmd_ready) begin
        if (nlog < 64) begin
          lg_ap[nlog] <= cmd_apndp; lg_a[nlog] <= cmd_addr; lg_d[nlog] <= cmd_wdata;
        end
        nlog      <= nlog + 1;
        rsp_valid <= 1'b1;
        rsp_ack   <= ack_for(nlog);
      end
    end
  end

  // Expected command list
  int          exp_n;
  logic        ex_ap [64];
  logic [1:0]  ex_a  [64];
  logic [31:0] ex_d  [64];
  logic [31:0] words [8];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic ex_add(input logic ap, input logic [1:0] a, input logic [31:0] d);
    ex_ap[exp_n] = ap; ex_a[exp_n] = a; ex_d[exp_n] = d; exp_n++;
  endtask

  // R2 R3 R4: full run order, SELECT only on port change
  task automatic mk_normal(input logic [31:0] base, input int n);
    exp_n = 0;
    ex_add(0, 2'b01, 32'h5000_0000);
    ex_add(0, 2'b10, 32'h0A00_0000);
    ex_add(1, 2'b01, 32'h0000_0008);
    ex_add(0, 2'b10, 32'h0000_0000);
    ex_add(1, 2'b00, 32'h0000_0012);
    ex_add(1, 2'b01, 32'hE000_EDF0); ex_add(1, 2'b11, 32'hA05F_0001);
    ex_add(1, 2'b01, 32'hE000_EDFC); ex_add(1, 2'b11, 32'h0000_0001);
    ex_add(1, 2'b01, 32'hE000_ED0C); ex_add(1, 2'b11, 32'hFA05_0004);
    ex_add(0, 2'b10, 32'h0A00_0000);
    ex_add(1, 2'b01, 32'h0000_0000);
    ex_add(0, 2'b10, 32'h0000_0000);
    ex_add(1, 2'b01, base);
    for (int k = 0; k < n; k++) ex_add(1, 2'b11, words[k]);
  endtask

  task automatic ex_dup(input int idx, input int cnt);
    for (int k = exp_n - 1; k > idx; k--) begin
      ex_ap[k+cnt] = ex_ap[k]; ex_a[k+cnt] = ex_a[k]; ex_d[k+cnt] = ex_d[k];
    end
    for (int k = 1; k <= cnt; k++) begin
      ex_ap[idx+k] = ex_ap[idx]; ex_a[idx+k] = ex_a[idx]; ex_d[idx+k] = ex_d[idx];
    end
    exp_n += cnt;
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    if (nlog == exp_n)
      for (int k = 0; k < exp_n; k++)
        if (bad < 0 && (lg_ap[k] !== ex_ap[k] || lg_a[k] !== ex_a[k] || lg_d[k] !== ex_d[k])) bad = k;
    if (nlog != exp_n) chk(0, {req, " command count"}, nlog, exp_n);
    else if (bad >= 0) chk(0, $sformatf("%s command %0d", req, bad),
                           {lg_ap[bad], lg_a[bad], lg_d[bad]}, {ex_ap[bad], ex_a[bad], ex_d[bad]});
    else chk(1, req, 0, 0);
  endtask

  task automatic run(input logic [31:0] base, input int n, input int gap, input bit extra_start);
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    base_addr = base;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    fork
      begin
        for (int k = 0; k < n; k++) begin
          wr_valid = 1'b1; wr_data = words[k]; wr_last = (k == n - 1);
          while (!wr_ready && busy) @(negedge clk);
          if (!busy) break;
          @(negedge clk);
          wr_valid = 1'b0;
          repeat (gap) @(negedge clk);
        end
        wr_valid = 1'b0;
      end
      begin
        int cyc = 0;
        while (!done && cyc < 3000) begin
          @(negedge clk); cyc++;
          start = extra_start && (cyc == 10);
        end
        start = 1'b0;
        if (!done) chk(0, "R8 run never finished", 0, 1);
      end
    join
  endtask

  task automatic clear_faults();
    wait_idx = 999; wait_n = 0; fault_idx = 999; bad_idx = 999; stall = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && cmd_valid == 0 && wr_ready == 0, "R1 reset idle outputs",
        {busy, done, cmd_valid, wr_ready}, 0);
    chk(err_code == 0 && words_written == 0, "R1 reset status", {err_code, words_written}, 0);
  endtask

  task automatic t_normal();
    clear_faults(); stall = 1'b1; wait_limit = 3;
    words[0] = 32'hDEAD_BEEF; words[1] = 32'h1234_5678; words[2] = 32'h0BAD_F00D;
    run(32'h2000_0000, 3, 2, 1'b0);
    chk(done == 1 && busy == 0, "R8 done pulse with busy low", {done, busy}, 2'b10);
    @(negedge clk);
    chk(done == 0, "R8 done lasts one cycle", done, 0);
    mk_normal(32'h2000_0000, 3);
    cmp_log("R2 R3 R4 R9 normal sequence under back-pressure");
    chk(err_code == 0, "R8 success code", err_code, 0);
    chk(words_written == 3, "R8 word count", words_written, 3);
  endtask

  task automatic t_wait_ok();
    clear_faults(); wait_limit = 3; wait_idx = 6; wait_n = 3;
    words[0] = 32'hCAFE_0001; words[1] = 32'hCAFE_0002;
    run(32'h2000_0100, 2, 0, 1'b0);
    mk_normal(32'h2000_0100, 2); ex_dup(6, 3);
    cmp_log("R5 WAIT at limit repeats same write");
    chk(err_code == 0 && words_written == 2, "R5 retry run succeeds", {err_code, words_written}, 2);
  endtask

  task automatic t_timeout();
    clear_faults(); wait_limit = 2; wait_idx = 4; wait_n = 50;
    words[0] = 32'h1;
    run(32'h2000_0000, 1, 0, 1'b0);
    mk_normal(32'h2000_0000, 1); exp_n = 5; ex_dup(4, 2);
    cmp_log("R5 timeout stops after limit+1 sends");
    chk(err_code == 2, "R5 timeout code", err_code, 2);
    chk(words_written == 0, "R8 no words on timeout", words_written, 0);
  endtask

  task automatic t_zero_limit();
    clear_faults(); wait_limit = 0; wait_idx = 0; wait_n = 1;
    run(32'h2000_0000, 1, 0, 1'b0);
    chk(nlog == 1 && err_code == 2, "R5 zero limit single WAIT ends run", {nlog, err_code}, {32'd1, 2'd2});
  endtask

  task automatic t_fault();
    clear_faults(); wait_limit = 3; fault_idx = 16;
    words[0] = 32'hAAAA_0000; words[1] = 32'hBBBB_1111; words[2] = 32'hCCCC_2222;
    run(32'h2000_0200, 3, 1, 1'b0);
    mk_normal(32'h2000_0200, 3); exp_n = 17; ex_add(0, 2'b00, 32'h0000_001E);
    cmp_log("R6 FAULT followed by ABORT clear");
    chk(err_code == 1, "R6 fault code", err_code, 1);
    chk(words_written == 1, "R8 count stops at fault", words_written, 1);
  endtask

  task automatic t_proto();
    clear_faults(); wait_limit = 3; bad_idx = 2;
    words[0] = 32'h5;
    run(32'h2000_0000, 1, 0, 1'b0);
    chk(nlog == 3, "R7 no command after bad acknowledge", nlog, 3);
    chk(err_code == 3, "R7 bad acknowledge code", err_code, 3);
  endtask

  task automatic t_restart();
    clear_faults(); wait_limit = 3;
    words[0] = 32'h7777_8888;
    run(32'h2000_0400, 1, 0, 1'b1);
    mk_normal(32'h2000_0400, 1);
    cmp_log("R1 R3 new run after error, start while busy ignored");
    chk(err_code == 0 && words_written == 1, "R8 status cleared by new run", {err_code, words_written}, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_wait_ok();
        t_timeout();
        t_zero_limit();
        t_fault();
        t_proto();
        t_restart();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule